// File: doc/BRIEF.md
# Two-step converter sequencing and bus control

This block is the digital sequencer of an 8-bit two-step (coarse, then residue) converter. The analog comparators stay outside. Each step hands the block a 15-bit thermometer code. The block counts the ones in each code to form a 4-bit nibble. It tells the front end when the input is being tracked and when each comparator pass is taken. It places the assembled byte on a processor-style bus through chip select, write, read, a mode pin and an active-low sleep pin.

Two bus modes are supported. In read-started mode, a falling read both starts a conversion and later fetches its result. In that mode an open-drain ready line is held low while the result is pending. In write-started mode, a falling write starts a conversion and the rising write captures the coarse nibble. The residue nibble is then captured after a counted delay, or earlier if read falls first. Tying write and read together in write-started mode gives a pipelined mode, in which each pulse reads the previous byte and launches the next conversion.

All time intervals are counted in clock cycles set by parameters: the residue delay, the wake-up time after sleep and the minimum tracking time after each conversion. The bus controls are sampled on the clock, and every edge is detected one cycle after it reaches the ports.

Top module: `hfadc_ctrl`

## Requirements
- R1: The result byte has the count of ones in the coarse code (0 to 15) in bits 7:4 and the count of ones in the residue code in bits 3:0. Each code is sampled on the clock edge that captures its nibble.
- R2: Write and read are ignored while chip select is high. A read or write pulse given with chip select high starts no conversion and leaves the result unchanged.
- R3: With mode low, a read falling while chip select is low and the block is idle captures the coarse nibble on that edge. The residue nibble is captured LSB_CYC edges later, and interrupt goes low on that edge. Ready pull-down asserts on the edge after chip select falls and releases on the completion edge.
- R4: Interrupt returns high on the edge after a rising read or a rising chip select, unless a completion happens on the same edge.
- R5: With mode high, a falling write (chip select low) starts a conversion. The rising write captures the coarse nibble from the code present at that edge. Without read, the residue nibble is captured and interrupt goes low LSB_CYC edges later.
- R6: With mode high, a read falling during the residue wait captures the residue nibble on that edge and drives interrupt low, ending the conversion early.
- R7: With mode high and write tied to read, a low pulse drives the previous result on the bus and starts a new conversion whose result appears on the next pulse.
- R8: While sleep is low, no request is accepted, interrupt is held high and tracking is off. After sleep rises, requests are ignored for WAKE_CYC + ACQ_CYC edges.
- R9: After each completion, a start request within the next ACQ_CYC edges is ignored.
- R10: The bus output enable is high only while chip select and read are both low, and the data pins read zero otherwise.
- R11: The tracking output is high while the block is waking, acquiring or idle, and low while it holds a sample or waits for the residue pass. The coarse and fine compare strobes mark the edges that capture each nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Low puts the block to sleep |
| mode_i | input | 1 | 0 read-started, 1 write-started |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write |
| rd_n | input | 1 | Active-low read |
| coarse_therm_i | input | 15 | Thermometer code of the coarse pass |
| fine_therm_i | input | 15 | Thermometer code of the residue pass |
| bus_data_o | output | 8 | Result byte, zero when not enabled |
| bus_oe_o | output | 1 | Bus drive enable; low means high impedance |
| int_n_o | output | 1 | Active-low end-of-conversion interrupt |
| rdy_pull_o | output | 1 | High means the open-drain ready line is pulled low |
| track_o | output | 1 | Front end tracks the input |
| coarse_cmp_o | output | 1 | Coarse nibble is captured on this edge |
| fine_cmp_o | output | 1 | Residue nibble is captured on this edge |

## Verification
Codes at both extremes (0 and 15) and at mixed mid values check the nibble packing. In write-started mode, the coarse code is changed right after write rises, which shows whether the upper nibble is taken at the rising write rather than later. An early read placed ahead of the internal delay is compared with the undisturbed delay, which separates the two completion paths. Back-to-back tied pulses with distinct codes show that the bus returns the previous byte. Requests made with chip select high, during sleep, during wake-up and just after a completion must all leave the result and interrupt untouched.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

   typedef enum logic [2:0] {
      HS_OFF,
      HS_WAKE,
      HS_ACQ,
      HS_IDLE,
      HS_HOLD,
      HS_FINE
   } hs_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hfadc_therm_enc.sv
module hfadc_therm_enc #(
   parameter int NIB      = 4,
   parameter bit POPCOUNT = 1'b1
) (
   input  logic [(1<<NIB)-2:0] therm_i,
   output logic [NIB-1:0]      code_o
);
   localparam int TW = (1 << NIB) - 1;

   generate
      if (POPCOUNT) begin : g_pop
         always_comb begin
            code_o = '0;
            for (int i = 0; i < TW; i++) begin
               code_o = code_o + NIB'(therm_i[i]);
            end
         end
      end else begin : g_top
         always_comb begin
            code_o = '0;
            for (int i = 0; i < TW; i++) begin
               if (therm_i[i]) code_o = NIB'(i + 1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hfadc_prev_reg.sv
module hfadc_prev_reg #(
   parameter int           W    = 4,
   parameter logic [W-1:0] INIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] prev_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= INIT;
      else        prev_o <= lvl_i;
   end
endmodule

// File: rtl/hfadc_timer.sv
module hfadc_timer
   import hfadc_pkg::*;
#(
   parameter int LSB_CYC  = 4,
   parameter int WAKE_CYC = 3,
   parameter int ACQ_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_n,
   input  logic mode_i,
   input  logic wr_fall,
   input  logic wr_rise,
   input  logic rd_fall,
   output logic latch_hi,
   output logic latch_lo,
   output logic track_o
);
   localparam int CNT_MAX = max3(LSB_CYC, WAKE_CYC, ACQ_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   hs_state_e        st, st_nx;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      st_nx    = st;
      latch_hi = 1'b0;
      latch_lo = 1'b0;
      if (!sleep_n) begin
         st_nx = HS_OFF;
      end else begin
         unique case (st)
            HS_OFF:  st_nx = HS_WAKE;
            HS_WAKE: if (cnt == CNT_W'(WAKE_CYC - 1)) st_nx = HS_ACQ;
            HS_ACQ:  if (cnt == CNT_W'(ACQ_CYC - 1))  st_nx = HS_IDLE;
            HS_IDLE: begin
               if (!mode_i && rd_fall) begin
                  latch_hi = 1'b1;
                  st_nx    = HS_FINE;
               end else if (mode_i && wr_fall) begin
                  st_nx = HS_HOLD;
               end
            end
            HS_HOLD: begin
               if (wr_rise) begin
                  latch_hi = 1'b1;
                  st_nx    = HS_FINE;
               end
            end
            HS_FINE: begin
               if ((cnt == CNT_W'(LSB_CYC - 1)) || (mode_i && rd_fall)) begin
                  latch_lo = 1'b1;
                  st_nx    = HS_ACQ;
               end
            end
            default: st_nx = HS_ACQ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= HS_ACQ;
         cnt <= '0;
      end else begin
         st <= st_nx;
         if (st_nx != st)                 cnt <= '0;
         else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + CNT_W'(1);
      end
   end

   assign track_o = (st == HS_WAKE) || (st == HS_ACQ) || (st == HS_IDLE);

   // R8: sleep forces the sequencer off on the next edge
   p_asleep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (st == HS_OFF));

   // R5: residue wait never runs past its programmed length
   p_fine_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == HS_FINE) |-> (cnt < CNT_W'(LSB_CYC)));

   // R9: every completion is followed by an acquisition interval
   p_rest_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      latch_lo |=> (st == HS_ACQ));

endmodule

// File: rtl/hfadc_ctrl.sv
module hfadc_ctrl #(
   parameter int NIB      = 4,
   parameter int LSB_CYC  = 4,
   parameter int WAKE_CYC = 3,
   parameter int ACQ_CYC  = 2,
   parameter bit POPCOUNT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_n,
   input  logic                 mode_i,
   input  logic                 cs_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic [(1<<NIB)-2:0]  coarse_therm_i,
   input  logic [(1<<NIB)-2:0]  fine_therm_i,
   output logic [2*NIB-1:0]     bus_data_o,
   output logic                 bus_oe_o,
   output logic                 int_n_o,
   output logic                 rdy_pull_o,
   output logic                 track_o,
   output logic                 coarse_cmp_o,
   output logic                 fine_cmp_o
);
   localparam int DW = 2 * NIB;

   generate
      if (NIB < 2 || NIB > 6) begin : g_bad_nib
         $error("hfadc_ctrl: NIB must lie in 2..6");
      end
      if (LSB_CYC < 1 || WAKE_CYC < 1 || ACQ_CYC < 1) begin : g_bad_cyc
         $error("hfadc_ctrl: cycle counts must be at least 1");
      end
   endgenerate

   // qualified bus strobes and their previous levels
   logic       wr_act, rd_act;
   logic [3:0] lvl, prev;
   assign wr_act = !cs_n && !wr_n;
   assign rd_act = !cs_n && !rd_n;
   assign lvl    = {cs_n, rd_n, rd_act, wr_act};

   hfadc_prev_reg #(.W(4), .INIT(4'b1100)) i_prev (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .prev_o (prev)
   );

   logic wr_fall, wr_rise, rd_fall, rd_up, cs_up, cs_fall;
   assign wr_fall = wr_act && !prev[0];
   assign wr_rise = !wr_act && prev[0];
   assign rd_fall = rd_act && !prev[1];
   assign rd_up   = rd_n && !prev[2];
   assign cs_up   = cs_n && !prev[3];
   assign cs_fall = !cs_n && prev[3];

   logic latch_hi, latch_lo;

   hfadc_timer #(
      .LSB_CYC  (LSB_CYC),
      .WAKE_CYC (WAKE_CYC),
      .ACQ_CYC  (ACQ_CYC)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_n  (sleep_n),
      .mode_i   (mode_i),
      .wr_fall  (wr_fall),
      .wr_rise  (wr_rise),
      .rd_fall  (rd_fall),
      .latch_hi (latch_hi),
      .latch_lo (latch_lo),
      .track_o  (track_o)
   );

   // one encoder per comparator pass
   logic [NIB-1:0] code [2];
   generate
      for (genvar g = 0; g < 2; g++) begin : g_enc
         hfadc_therm_enc #(.NIB(NIB), .POPCOUNT(POPCOUNT)) i_enc (
            .therm_i ((g == 0) ? fine_therm_i : coarse_therm_i),
            .code_o  (code[g])
         );
      end
   endgenerate

   logic [DW-1:0] result_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
      end else begin
         if (latch_hi) result_q[DW-1:NIB] <= code[1];
         if (latch_lo) result_q[NIB-1:0]  <= code[0];
      end
   end

   logic int_n_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                int_n_q <= 1'b1;
      else if (!sleep_n)         int_n_q <= 1'b1;
      else if (latch_lo)         int_n_q <= 1'b0;
      else if (rd_up || cs_up)   int_n_q <= 1'b1;
   end

   logic rdy_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  rdy_q <= 1'b0;
      else if (latch_lo || cs_n)                   rdy_q <= 1'b0;
      else if (!mode_i && cs_fall && sleep_n)      rdy_q <= 1'b1;
   end

   assign bus_oe_o     = rd_act;
   assign bus_data_o   = rd_act ? result_q : '0;
   assign int_n_o      = int_n_q;
   assign rdy_pull_o   = rdy_q;
   assign coarse_cmp_o = latch_hi;
   assign fine_cmp_o   = latch_lo;

   // R3: completion pulls interrupt low on the next edge
   p_done_int_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_lo |=> !int_n_o);

   // R3: completion releases the ready line
   p_done_rdy_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_lo |=> !rdy_pull_o);

   // R4: a rising read or chip select clears interrupt when no completion coincides
   p_int_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_n && !latch_lo && ($rose(rd_n) || $rose(cs_n))) |=> int_n_o);

endmodule

// File: tb/test_hfadc_ctrl.sv
module test_hfadc_ctrl;
   localparam int CLK_NS   = 10;
   localparam int LSB      = 4;
   localparam int WAKE     = 3;
   localparam int ACQ      = 2;
   localparam int WATCHDOG = 5000;

   localparam int M_IDLE = 0;
   localparam int M_HOLD = 1;
   localparam int M_FINE = 2;
   localparam int M_OFF  = 3;

   logic clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic        rst_n = 1'b0;
   logic        sleep_n = 1'b1;
   logic        mode = 1'b0;
   logic        cs_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [14:0] th_hi = '0;
   logic [14:0] th_lo = '0;
   logic [7:0]  bus_data;
   logic        bus_oe, int_n, rdy_pull, track, cmp_hi, cmp_lo;

   hfadc_ctrl #(
      .NIB(4), .LSB_CYC(LSB), .WAKE_CYC(WAKE), .ACQ_CYC(ACQ), .POPCOUNT(1'b1)
   ) i_hfadc_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .sleep_n        (sleep_n),
      .mode_i         (mode),
      .cs_n           (cs_n),
      .wr_n           (wr_n),
      .rd_n           (rd_n),
      .coarse_therm_i (th_hi),
      .fine_therm_i   (th_lo),
      .bus_data_o     (bus_data),
      .bus_oe_o       (bus_oe),
      .int_n_o        (int_n),
      .rdy_pull_o     (rdy_pull),
      .track_o        (track),
      .coarse_cmp_o   (cmp_hi),
      .fine_cmp_o     (cmp_lo)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic logic [14:0] therm(input int k);
      return 15'((32'd1 << k) - 32'd1);
   endfunction

   function automatic int ones(input logic [14:0] v);
      int n = 0;
      foreach (v[i]) if (v[i]) n++;
      return n;
   endfunction

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference model, advanced on every rising edge
   int  cyc = 0;
   int  m_phase = M_IDLE;
   int  m_ready = ACQ + 1;
   int  m_due = 0;
   int  m_res = 0;
   bit  m_int = 1'b1;
   bit  m_rdy = 1'b0;
   bit  p_cs = 1'b1, p_rd = 1'b1, p_rda = 1'b0, p_wra = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cyc = 0; m_phase = M_IDLE; m_ready = ACQ + 1; m_res = 0;
         m_int = 1'b1; m_rdy = 1'b0;
         p_cs = 1'b1; p_rd = 1'b1; p_rda = 1'b0; p_wra = 1'b0;
      end else begin
         bit rda, wra, rdf, wrf, wrr, fin;
         cyc++;
         rda = !cs_n && !rd_n;
         wra = !cs_n && !wr_n;
         rdf = rda && !p_rda;
         wrf = wra && !p_wra;
         wrr = !wra && p_wra;
         fin = 1'b0;
         if (!sleep_n) begin
            m_phase = M_OFF;
         end else begin
            case (m_phase)
               M_OFF: begin
                  m_phase = M_IDLE;
                  m_ready = cyc + WAKE + ACQ + 1;
               end
               M_IDLE: if (cyc >= m_ready) begin
                  if (!mode && rdf) begin
                     m_res = (ones(th_hi) << 4) | (m_res & 15);
                     m_phase = M_FINE; m_due = cyc + LSB;
                  end else if (mode && wrf) begin
                     m_phase = M_HOLD;
                  end
               end
               M_HOLD: if (wrr) begin
                  m_res = (ones(th_hi) << 4) | (m_res & 15);
                  m_phase = M_FINE; m_due = cyc + LSB;
               end
               default: if (cyc == m_due || (mode && rdf)) begin
                  m_res = (m_res & 8'hF0) | ones(th_lo);
                  fin = 1'b1;
                  m_phase = M_IDLE; m_ready = cyc + ACQ + 1;
               end
            endcase
         end
         if (!sleep_n)                              m_int = 1'b1;
         else if (fin)                              m_int = 1'b0;
         else if ((rd_n && !p_rd) || (cs_n && !p_cs)) m_int = 1'b1;
         if (fin || cs_n)                           m_rdy = 1'b0;
         else if (!mode && p_cs && sleep_n)         m_rdy = 1'b1;
         p_cs = cs_n; p_rd = rd_n; p_rda = rda; p_wra = wra;
         #2;
         if (rst_n && !done) begin
            chk("R4 model int_n", int'(int_n), int'(m_int));
            chk("R3 model ready", int'(rdy_pull), int'(m_rdy));
            chk("R10 model bus enable", int'(bus_oe), int'(!cs_n && !rd_n));
            chk("R11 model tracking", int'(track), int'(m_phase == M_IDLE));
            if (!cs_n && !rd_n) chk("R1 model data", int'(bus_data), m_res);
            else                chk("R10 model idle data", int'(bus_data), 0);
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      chk("R4 reset int_n", int'(int_n), 1);
      chk("R3 reset ready", int'(rdy_pull), 0);
      chk("R10 reset bus enable", int'(bus_oe), 0);
      chk("R11 reset tracking", int'(track), 1);
      tick(4);

      // read-started conversion
      mode = 1'b0; cs_n = 1'b0; th_hi = therm(9); th_lo = therm(3);
      tick();
      chk("R3 ready after cs fall", int'(rdy_pull), 1);
      rd_n = 1'b0;
      tick();
      tick(LSB - 1);
      chk("R3 int still high before delay", int'(int_n), 1);
      tick();
      chk("R3 int low at completion", int'(int_n), 0);
      chk("R3 ready released", int'(rdy_pull), 0);
      chk("R1 read result 0x93", int'(bus_data), 8'h93);
      rd_n = 1'b1;
      tick();
      chk("R4 int high after rd rise", int'(int_n), 1);
      cs_n = 1'b1;
      tick(3);

      // write-started conversion, coarse taken at rising write
      mode = 1'b1; cs_n = 1'b0; th_hi = therm(15); wr_n = 1'b0;
      tick();
      chk("R11 tracking off while holding", int'(track), 0);
      tick();
      wr_n = 1'b1;
      tick();
      th_hi = therm(2); th_lo = therm(0);
      tick(LSB - 1);
      chk("R5 int high before delay", int'(int_n), 1);
      tick();
      chk("R5 int low after delay", int'(int_n), 0);
      rd_n = 1'b0;
      tick();
      chk("R5 R1 result 0xF0", int'(bus_data), 8'hF0);
      rd_n = 1'b1;
      tick();
      chk("R4 int high after read", int'(int_n), 1);
      cs_n = 1'b1;
      tick(3);

      // early read cuts the residue delay
      cs_n = 1'b0; th_hi = therm(5); th_lo = therm(12); wr_n = 1'b0;
      tick();
      wr_n = 1'b1;
      tick(2);
      rd_n = 1'b0;
      tick();
      chk("R6 int low on early read", int'(int_n), 0);
      chk("R6 early result 0x5C", int'(bus_data), 8'h5C);
      cs_n = 1'b1;
      tick();
      chk("R4 int high after cs rise", int'(int_n), 1);
      chk("R10 bus off with cs high", int'(bus_oe), 0);
      rd_n = 1'b1;
      tick(3);

      // pipelined pulses
      cs_n = 1'b0; th_hi = therm(7); th_lo = therm(7);
      wr_n = 1'b0; rd_n = 1'b0;
      tick();
      chk("R7 bus enabled in pulse", int'(bus_oe), 1);
      chk("R7 previous result 0x5C", int'(bus_data), 8'h5C);
      wr_n = 1'b1; rd_n = 1'b1;
      tick(1 + LSB);
      chk("R7 int low after pulse", int'(int_n), 0);
      th_hi = therm(1); th_lo = therm(14);
      tick(3);
      wr_n = 1'b0; rd_n = 1'b0;
      tick();
      chk("R7 previous result 0x77", int'(bus_data), 8'h77);
      wr_n = 1'b1; rd_n = 1'b1;
      tick(1 + LSB + 3);
      wr_n = 1'b0; rd_n = 1'b0;
      tick();
      chk("R7 previous result 0x1E", int'(bus_data), 8'h1E);
      wr_n = 1'b1; rd_n = 1'b1;
      tick(1 + LSB);
      cs_n = 1'b1;
      tick(3);

      // chip select high: read ignored
      mode = 1'b0; th_hi = therm(8); th_lo = therm(8); rd_n = 1'b0;
      tick(LSB + 2);
      chk("R2 no conversion with cs high", int'(int_n), 1);
      chk("R10 bus off with cs high", int'(bus_oe), 0);
      rd_n = 1'b1;
      tick();
      mode = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
      tick();
      chk("R2 result unchanged 0x1E", int'(bus_data), 8'h1E);
      rd_n = 1'b1; cs_n = 1'b1;
      tick(3);

      // sleep and wake-up
      sleep_n = 1'b0; th_hi = therm(4); th_lo = therm(11);
      tick();
      chk("R8 tracking off asleep", int'(track), 0);
      mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
      tick(LSB + 2);
      chk("R8 no conversion asleep", int'(int_n), 1);
      chk("R8 ready not pulled asleep", int'(rdy_pull), 0);
      rd_n = 1'b1; cs_n = 1'b1;
      tick();
      sleep_n = 1'b1;
      tick();
      cs_n = 1'b0; rd_n = 1'b0;
      tick(1 + LSB + 2);
      chk("R8 request ignored during wake", int'(int_n), 1);
      rd_n = 1'b1;
      tick();
      rd_n = 1'b0;
      tick(LSB);
      tick();
      chk("R8 conversion after wake", int'(int_n), 0);
      chk("R8 R1 result 0x4B", int'(bus_data), 8'h4B);
      rd_n = 1'b1; cs_n = 1'b1;
      tick(3);

      // acquisition guard after completion
      mode = 1'b1; cs_n = 1'b0; th_hi = therm(10); th_lo = therm(6); wr_n = 1'b0;
      tick();
      wr_n = 1'b1;
      tick(1 + LSB);
      chk("R5 int low after delay", int'(int_n), 0);
      th_hi = therm(3); th_lo = therm(3); wr_n = 1'b0;
      tick();
      wr_n = 1'b1;
      tick(1 + LSB + 1);
      rd_n = 1'b0;
      tick();
      chk("R9 start in acquisition ignored 0xA6", int'(bus_data), 8'hA6);
      rd_n = 1'b1; cs_n = 1'b1;
      tick(3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule